// File: doc/BRIEF.md
# Byte-to-Word Shared Memory Bridge

This block sits between an 8-bit host processor and a 128-word by 32-bit data memory. A 32-bit compute engine also reads and writes that memory, and the two sides use it as their main channel for exchanging data. The host addresses single bytes. The bridge turns those byte accesses into whole-word accesses on the memory port by keeping holding registers: one assembles the bytes of a word being written, and one keeps a copy of the word being read.

A host read of the lowest byte lane fetches the full word. Reads of the other lanes are served from the held copy. Host writes to the three lower lanes only fill the write holding register. A write to the top lane commits all 32 bits in a single memory write.

The host is stalled through a ready signal. The number of wait states is selected by a rate code that matches the host clock frequency. Sharing with the engine is reduced to a grant input: the bridge touches the memory only in cycles where grant is high, and keeps the host stalled until then.

Top module: `byte_word_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, host_ready is 1 and mem_en is 0. host_rdata resets to 0.
- R2: rate_sel selects the wait-state count: code 0 gives 5 (about 4.9 MHz host clock), code 1 gives 2 (about 1.25 MHz), code 2 gives 1 (about 614 kHz) and code 3 gives 0. An access that needs no memory cycle holds host_ready low for exactly that many cycles after the edge that accepts the strobe.
- R3: The host address carries the word index in bits [8:2] and the byte lane in bits [1:0]. A read of lane 0 performs one memory read of the addressed word, whose data arrives on mem_rdata one cycle later. It returns bits [7:0] on host_rdata. host_ready stays low for the wait count plus 2 cycles when grant is held high.
- R4: A read of lane L (1 to 3) returns bits [8L+7:8L] of the word fetched by the most recent lane-0 read, without any memory cycle.
- R5: A write to lane 0, 1 or 2 stores the byte in the write holding register only. No memory cycle occurs and the memory contents are unchanged.
- R6: A write to lane 3 performs exactly one memory write to the word addressed by that access. The written data is {written byte, held lane 2, held lane 1, held lane 0}. host_ready stays low for the wait count plus 1 cycle when grant is held high.
- R7: mem_en is high only in cycles where mem_grant is high. Each cycle in which a pending memory access finds grant low adds one cycle to the stall. Grant low during the wait-state count adds nothing.
- R8: A strobe presented while host_ready is low is ignored. It causes no memory cycle and leaves the holding registers unchanged.
- R9: If host_rd and host_wr are both high on an accepted strobe, the access is treated as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 9 | Host byte address: word index [8:2], lane [1:0] |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe, taken when host_ready is high |
| host_wr | input | 1 | Host write strobe, taken when host_ready is high |
| host_rdata | output | 8 | Host read byte, valid once host_ready returns high |
| host_ready | output | 1 | High when the bridge can take a new strobe |
| rate_sel | input | 2 | Host clock rate code that selects the wait-state count |
| mem_grant | input | 1 | Memory access permitted this cycle |
| mem_en | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 7 | Memory word index |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, one cycle after a read request |

## Verification
The hardest situation to reach from the ports is grant being low exactly when an access leaves its wait-state count and reaches the memory phase. The stall must then grow by the number of grant-low memory-phase cycles and by nothing else. The bench lowers grant before the strobe and raises it a counted number of edges after the accepting edge. It uses gaps both longer and shorter than the configured wait count, for reads and for commits. A second hard case is a stray write strobe to the top lane arriving mid-wait. The bench injects one and then shows at the ports that no write happened and that the held bytes survived, through a later commit.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int LANE_W = $clog2(LANES);
    localparam int WAIT_W = 3;

    // Host clock rate codes, fastest first
    typedef enum logic [1:0] {
        RATE_FULL    = 2'd0,
        RATE_QUARTER = 2'd1,
        RATE_EIGHTH  = 2'd2,
        RATE_SLOW    = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_FILL
    } state_e;

    // One host byte request as seen at the strobe
    typedef struct packed {
        logic              wr;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] data;
    } host_req_t;

    function automatic logic [WAIT_W-1:0] waits_for_rate(input rate_e r);
        case (r)
            RATE_FULL:    return WAIT_W'(5);
            RATE_QUARTER: return WAIT_W'(2);
            RATE_EIGHTH:  return WAIT_W'(1);
            default:      return WAIT_W'(0);
        endcase
    endfunction

    // Lane 0 reads fetch, top-lane writes commit; all else stays local
    function automatic logic lane_needs_mem(input logic is_wr, input logic [LANE_W-1:0] lane);
        if (is_wr)
            return lane == LANE_W'(LANES - 1);
        return lane == '0;
    endfunction

endpackage

// File: rtl/bwb_wait_timer.sv
module bwb_wait_timer #(
    parameter int CNT_W = bwb_pkg::WAIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/bwb_hold_regs.sv
module bwb_hold_regs
    import bwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    // write side
    input  logic              wr_byte_en,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [BYTE_W-1:0] top_byte,
    output logic [WORD_W-1:0] commit_word,
    // read side
    input  logic              rd_lane_en,
    input  logic [LANE_W-1:0] rd_lane,
    input  logic              fill_en,
    input  logic [WORD_W-1:0] fill_word,
    output logic [BYTE_W-1:0] rdata
);

    // Lower lanes of the outgoing word are held; the top lane is the committing byte
    genvar g;
    generate
        for (g = 0; g < LANES - 1; g++) begin : g_wlane
            logic [BYTE_W-1:0] lane_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lane_q <= '0;
                end else if (wr_byte_en && wr_lane == LANE_W'(g)) begin
                    lane_q <= wr_byte;
                end
            end
            assign commit_word[g*BYTE_W +: BYTE_W] = lane_q;
        end
    endgenerate

    assign commit_word[WORD_W-1 -: BYTE_W] = top_byte;

    logic [WORD_W-1:0] rhold_q;
    logic [BYTE_W-1:0] rdata_q;
    logic [BYTE_W-1:0] rlanes [LANES];

    generate
        for (g = 0; g < LANES; g++) begin : g_rlane
            assign rlanes[g] = rhold_q[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rhold_q <= '0;
            rdata_q <= '0;
        end else if (fill_en) begin
            rhold_q <= fill_word;
            rdata_q <= fill_word[BYTE_W-1:0];
        end else if (rd_lane_en) begin
            rdata_q <= rlanes[rd_lane];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/bwb_ctrl.sv
module bwb_ctrl
    import bwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              accept_mem,
    input  logic              accept_wr,
    input  logic [WAIT_W-1:0] wait_n,
    input  logic              timer_last,
    input  logic              grant,
    output logic              ready,
    output logic              timer_load,
    output logic              timer_run,
    output logic              mem_en,
    output logic              mem_we,
    output logic              fill_en
);

    state_e st_q, st_d;
    logic   mem_q;
    logic   wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            mem_q <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                mem_q <= accept_mem;
                wr_q  <= accept_wr;
            end
        end
    end

    always_comb begin
        st_d    = st_q;
        mem_en  = 1'b0;
        fill_en = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    if (wait_n != '0)
                        st_d = ST_WAIT;
                    else if (accept_mem)
                        st_d = ST_ISSUE;
                end
            end
            ST_WAIT: begin
                if (timer_last)
                    st_d = mem_q ? ST_ISSUE : ST_IDLE;
            end
            ST_ISSUE: begin
                if (grant) begin
                    mem_en = 1'b1;
                    st_d   = wr_q ? ST_IDLE : ST_FILL;
                end
            end
            ST_FILL: begin
                fill_en = 1'b1;
                st_d    = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign ready      = (st_q == ST_IDLE);
    assign timer_load = accept;
    assign timer_run  = (st_q == ST_WAIT);
    assign mem_we     = mem_en & wr_q;

endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
    import bwb_pkg::*;
#(
    parameter  int WORDS   = 128,
    localparam int ADDR_W  = $clog2(WORDS),
    localparam int HOST_AW = ADDR_W + LANE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    input  logic               host_rd,
    input  logic               host_wr,
    output logic [BYTE_W-1:0]  host_rdata,
    output logic               host_ready,
    input  logic [1:0]         rate_sel,
    input  logic               mem_grant,
    output logic               mem_en,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata
);

    host_req_t         in_req;
    host_req_t         req_q;
    logic [ADDR_W-1:0] in_word;
    logic [ADDR_W-1:0] word_q;
    logic              ready;
    logic              accept;
    logic              acc_mem;
    logic [WAIT_W-1:0] wait_n;
    logic              timer_load;
    logic              timer_run;
    logic              timer_last;
    logic              fill_en;

    assign in_req.wr   = host_wr;
    assign in_req.lane = host_addr[LANE_W-1:0];
    assign in_req.data = host_wdata;
    assign in_word     = host_addr[HOST_AW-1:LANE_W];

    assign accept  = ready & (host_rd | host_wr);
    assign acc_mem = lane_needs_mem(in_req.wr, in_req.lane);
    assign wait_n  = waits_for_rate(rate_e'(rate_sel));

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            word_q <= '0;
        end else if (accept) begin
            req_q  <= in_req;
            word_q <= in_word;
        end
    end

    bwb_wait_timer #(
        .CNT_W(WAIT_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .load_val(wait_n),
        .run     (timer_run),
        .last    (timer_last)
    );

    bwb_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .accept_mem(acc_mem),
        .accept_wr (in_req.wr),
        .wait_n    (wait_n),
        .timer_last(timer_last),
        .grant     (mem_grant),
        .ready     (ready),
        .timer_load(timer_load),
        .timer_run (timer_run),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .fill_en   (fill_en)
    );

    bwb_hold_regs hold_i (
        .clk        (clk),
        .rst        (rst),
        .wr_byte_en (accept & in_req.wr & (in_req.lane != LANE_W'(LANES - 1))),
        .wr_lane    (in_req.lane),
        .wr_byte    (in_req.data),
        .top_byte   (req_q.data),
        .commit_word(mem_wdata),
        .rd_lane_en (accept & ~in_req.wr & (in_req.lane != '0)),
        .rd_lane    (in_req.lane),
        .fill_en    (fill_en),
        .fill_word  (mem_rdata),
        .rdata      (host_rdata)
    );

    assign host_ready = ready;
    assign mem_addr   = word_q;

endmodule

// File: rtl/bwb_checker.sv
module bwb_checker
    import bwb_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int HOST_AW = 9
) (
    input logic               clk,
    input logic               rst,
    input logic [HOST_AW-1:0] host_addr,
    input logic               host_rd,
    input logic               host_wr,
    input logic               host_ready,
    input logic [1:0]         rate_sel,
    input logic               mem_grant,
    input logic               mem_en,
    input logic               mem_we
);

    logic strobe_taken;
    logic local_only;

    assign strobe_taken = host_ready && (host_rd || host_wr);
    assign local_only   = host_wr ? (host_addr[LANE_W-1:0] != LANE_W'(LANES - 1))
                                  : (host_addr[LANE_W-1:0] != '0);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (host_ready && !mem_en));

    a_r7_grant_only: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> mem_grant);

    a_r3_fill_stalls: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> !host_ready);

    a_r5_partial_no_mem: assert property (@(posedge clk) disable iff (rst)
        (strobe_taken && host_wr && local_only) |=> !mem_en);

    a_r2_waits_stall: assert property (@(posedge clk) disable iff (rst)
        (strobe_taken && rate_sel != 2'd3) |=> !host_ready);

    a_r2_zero_wait_local: assert property (@(posedge clk) disable iff (rst)
        (strobe_taken && rate_sel == 2'd3 && local_only) |=> host_ready);

endmodule

bind byte_word_bridge bwb_checker #(
    .ADDR_W (ADDR_W),
    .HOST_AW(HOST_AW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_ready(host_ready),
    .rate_sel  (rate_sel),
    .mem_grant (mem_grant),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
);

// File: tb/byte_word_bridge_tb_top.sv
module byte_word_bridge_tb_top;

    localparam int AW = 7;

    typedef struct {
        bit          is_rd;
        logic [7:0]  rdata;
        int          low;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic [1:0]  rate_sel = 2'd3;
    logic        mem_grant = 1'b1;
    logic        mem_en;
    logic        mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem     [128];
    logic [31:0] ref_mem [128];
    int          mem_writes = 0;
    int          mem_reads  = 0;
    logic [31:0] held_word = '0;
    logic [7:0]  whold [3];

    int   nchecks = 0;
    int   nerr    = 0;
    bit   done    = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    byte_word_bridge dut_i (
        .clk       (clk),
        .rst       (rst),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .host_rdata(host_rdata),
        .host_ready(host_ready),
        .rate_sel  (rate_sel),
        .mem_grant (mem_grant),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                mem_writes    <= mem_writes + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                mem_reads <= mem_reads + 1;
            end
        end
    end

    function automatic logic [31:0] init_word(input int i);
        return {8'(i) ^ 8'h5A, 8'(i) ^ 8'hC3, 8'(i) ^ 8'h3C, 8'(i)};
    endfunction

    function automatic int exp_waits(input logic [1:0] r);
        case (r)
            2'd0: return 5;
            2'd1: return 2;
            2'd2: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: push expectation, present one strobe, wait for completion
    task automatic host_op(input bit do_rd, input bit do_wr, input int word, input int lane,
                           input logic [7:0] wbyte, input logic [1:0] rate,
                           input int low, input logic [7:0] exp_rd, input string tag);
        exp_t e;
        e.is_rd = do_rd && !do_wr;
        e.rdata = exp_rd;
        e.low   = low;
        e.tag   = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
        host_addr  = {7'(word), 2'(lane)};
        host_wdata = wbyte;
        rate_sel   = rate;
        host_rd    = do_rd;
        host_wr    = do_wr;
        @(posedge clk);
        #1;
        host_rd = 1'b0;
        host_wr = 1'b0;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
    endtask

    task automatic do_read(input int word, input int lane, input logic [1:0] rate,
                           input int g, input string tag);
        int low;
        low = exp_waits(rate) + ((lane == 0) ? 2 + g : 0);
        if (lane == 0) held_word = ref_mem[word];
        host_op(1'b1, 1'b0, word, lane, 8'h00, rate, low, held_word[lane*8 +: 8], tag);
    endtask

    task automatic do_write(input bit also_rd, input int word, input int lane,
                            input logic [7:0] b, input logic [1:0] rate,
                            input int g, input string tag);
        int low;
        low = exp_waits(rate);
        if (lane < 3) begin
            whold[lane] = b;
        end else begin
            low = low + 1 + g;
            ref_mem[word] = {b, whold[2], whold[1], whold[0]};
        end
        host_op(also_rd, 1'b1, word, lane, b, rate, low, 8'h00, tag);
    endtask

    task automatic gap_read(input int word, input logic [1:0] rate, input int k, input string tag);
        int g;
        g = (k > exp_waits(rate)) ? k - exp_waits(rate) : 0;
        mem_grant = 1'b0;
        fork
            do_read(word, 0, rate, g, tag);
            begin
                repeat (2 + k) @(posedge clk);
                #1 mem_grant = 1'b1;
            end
        join
    endtask

    task automatic gap_write(input int word, input logic [7:0] b, input logic [1:0] rate,
                             input int k, input string tag);
        int g;
        g = (k > exp_waits(rate)) ? k - exp_waits(rate) : 0;
        mem_grant = 1'b0;
        fork
            do_write(1'b0, word, 3, b, rate, g, tag);
            begin
                repeat (2 + k) @(posedge clk);
                #1 mem_grant = 1'b1;
            end
        join
    endtask

    task automatic check_word(input int word, input string req);
        check(mem[word] === ref_mem[word], req, $sformatf("memory word %0d", word),
              mem[word], ref_mem[word]);
    endtask

    // Monitor: measure stall per accepted strobe, compare against scoreboard
    bit   mon_busy = 0;
    int   mon_low  = 0;
    exp_t mon_e;
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                mon_busy = 0;
            end else begin
                if (mon_busy) begin
                    if (!host_ready) begin
                        mon_low++;
                    end else begin
                        mon_busy = 0;
                        if (sb_q.size() == 0) begin
                            check(1'b0, "R2", "unexpected completion", 0, 1);
                        end else begin
                            mon_e = sb_q.pop_front();
                            check(mon_low == mon_e.low, mon_e.tag, "stall cycles",
                                  mon_low, mon_e.low);
                            if (mon_e.is_rd)
                                check(host_rdata === mon_e.rdata, mon_e.tag, "read byte",
                                      host_rdata, mon_e.rdata);
                        end
                    end
                end
                if (!mon_busy && host_ready && (host_rd || host_wr)) begin
                    mon_busy = 1;
                    mon_low  = 0;
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int wr0;
        int rd0;
        for (int i = 0; i < 128; i++) begin
            mem[i]     = init_word(i);
            ref_mem[i] = init_word(i);
        end
        for (int i = 0; i < 3; i++) whold[i] = 8'h00;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(host_ready === 1'b1, "R1", "ready in reset", host_ready, 1);
        check(host_rdata === 8'h00, "R1", "rdata in reset", host_rdata, 0);
        check(mem_en === 1'b0, "R1", "mem_en in reset", mem_en, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(host_ready === 1'b1, "R1", "ready after reset", host_ready, 1);

        // R2, R3, R4: full-word read then lane reads at every rate
        for (int r = 0; r < 4; r++) begin
            do_read(5 + r, 0, 2'(r), 0, "R3");
            rd0 = mem_reads;
            for (int l = 1; l < 4; l++) do_read(5 + r, l, 2'(r), 0, "R4");
            check(mem_reads == rd0, "R4", "memory reads for lanes 1-3", mem_reads, rd0);
        end

        // R5: partial writes touch only the holding register
        wr0 = mem_writes;
        do_write(1'b0, 9, 0, 8'h11, 2'd2, 0, "R5");
        do_write(1'b0, 9, 1, 8'h22, 2'd2, 0, "R5");
        do_write(1'b0, 9, 2, 8'h33, 2'd0, 0, "R5");
        check(mem_writes == wr0, "R5", "memory writes after partial", mem_writes, wr0);
        check_word(9, "R5");
        do_read(9, 0, 2'd3, 0, "R5");

        // R6: commit to a different word, one write, readback of all lanes
        wr0 = mem_writes;
        do_write(1'b0, 20, 3, 8'h44, 2'd1, 0, "R6");
        check(mem_writes == wr0 + 1, "R6", "single commit write", mem_writes, wr0 + 1);
        check_word(20, "R6");
        check_word(9, "R6");
        for (int l = 0; l < 4; l++) do_read(20, l, 2'd2, 0, "R6");

        // R7: grant gaps longer and shorter than the wait count
        gap_read(21, 2'd3, 4, "R7");
        gap_write(30, 8'h5C, 2'd3, 2, "R7");
        check_word(30, "R7");
        gap_read(30, 2'd1, 5, "R7");
        gap_write(31, 8'hA7, 2'd0, 3, "R7");
        check_word(31, "R7");
        gap_read(31, 2'd2, 1, "R7");

        // R8: stray top-lane write strobe during a busy partial write
        wr0 = mem_writes;
        fork
            do_write(1'b0, 50, 1, 8'hEE, 2'd0, 0, "R8");
            begin
                repeat (4) @(posedge clk);
                #1;
                host_addr  = {7'd51, 2'd3};
                host_wdata = 8'h99;
                host_wr    = 1'b1;
                @(posedge clk);
                #1 host_wr = 1'b0;
            end
        join
        check(mem_writes == wr0, "R8", "writes after stray strobe", mem_writes, wr0);
        check_word(51, "R8");
        do_write(1'b0, 51, 3, 8'h12, 2'd3, 0, "R8");
        check_word(51, "R8");

        // R9: both strobes act as a write
        wr0 = mem_writes;
        do_write(1'b1, 40, 3, 8'h77, 2'd2, 0, "R9");
        check(mem_writes == wr0 + 1, "R9", "dual strobe writes", mem_writes, wr0 + 1);
        check_word(40, "R9");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule